// File: doc/BRIEF.md
# Fixed-Window Flash Map Control and Address Translator

This block holds a small control register that decides how a 16-bit CPU's fixed program window is placed in a 23-bit global address space. Three bits are held. The first enables emulated ROM and can be set only through a dedicated load strobe. The second moves the fixed window onto external space. The third enables the on-chip Flash.

Write permission depends on the operating mode. In normal and emulation modes the two software-writable bits take only the first write after reset. In special mode they take every write.

The translator is combinational and works from the current register state. CPU local addresses in the window 0x4000–0x7FFF go either to on-chip Flash at global 0x7F_4000–0x7F_7FFF or to external space at 0x14_4000–0x14_7FFF. The block raises an external-access flag whenever the access leaves the chip. In emulation mode, register reads return the external bus data and register writes are also signalled to the external bus.

Top module: `flashmap_ctl`

## Requirements
- R1: After reset all register bits are 0, and a read in a non-emulation mode returns 0x00.
- R2: Read-back layout is bit 2 = emulated-ROM enable, bit 1 = high-half-only, bit 0 = Flash enable. Bits 7..3 read as 0 in every mode except emulation.
- R3: Software writes never change bit 2. Bit 2 takes `erom_ld_val` only in a cycle where `erom_ld` is 1.
- R4: In normal mode (`mode`=2'b00) and emulation mode (`mode`=2'b01), bits 1 and 0 accept only the first register write after reset. Every later write leaves them unchanged.
- R5: In special mode (`mode`=2'b10 or 2'b11), bits 1 and 0 accept every write.
- R6: With high-half-only = 0 and Flash enable = 1, a local address 0x4000–0x7FFF maps to {7'h7F, addr}, and `ext_acc` = 0.
- R7: With high-half-only = 1, a local address 0x4000–0x7FFF maps to {7'h14, addr}, and `ext_acc` = 1.
- R8: With Flash enable = 0 and high-half-only = 0, a window access maps to {7'h7F, addr} with `ext_acc` = 1.
- R9: A local address outside 0x4000–0x7FFF maps to {7'h7F, addr} with `ext_acc` = 0, whatever the register holds.
- R10: In emulation mode, `reg_rdata` equals `ext_rdata`, and `ext_wr` is 1 exactly in the cycles where `reg_wr` is 1. In other modes `ext_wr` is 0.
- R11: A register write changes the translation from the clock edge that captures it. Before that edge the old mapping holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 normal, 01 emulation, 1x special |
| erom_ld | input | 1 | Load strobe for the emulated-ROM enable bit |
| erom_ld_val | input | 1 | Value loaded into the emulated-ROM enable bit |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| ext_rdata | input | 8 | External bus read data, used in emulation mode |
| reg_rdata | output | 8 | Register read data |
| ext_wr | output | 1 | Write forwarded to the external bus |
| cpu_addr | input | 16 | CPU local address |
| glb_addr | output | 23 | Translated global address |
| ext_acc | output | 1 | Access targets external space |

## Verification
The register write and the translation can fall in the same cycle. The bench provokes this by changing the window bits with a write while a window address is held steady. It judges the case by sampling the global address before the capturing edge, where the old mapping must hold, and again after that edge, where the new mapping must hold.

A second overlap is a write that arrives after the first one in normal mode. The bench issues that write and then checks that the translation does not move. It then switches to special mode with the same register contents and checks that the same write now takes effect.

// File: rtl/flashmap_ctl.sv
module flashmap_ctl #(
  parameter int LADDR_W = 16,
  parameter int GADDR_W = 23,
  parameter logic [GADDR_W-LADDR_W-1:0] FLASH_PG = 7'h7F,
  parameter logic [GADDR_W-LADDR_W-1:0] EXT_PG   = 7'h14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               erom_ld,
  input  logic               erom_ld_val,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  input  logic [7:0]         ext_rdata,
  output logic [7:0]         reg_rdata,
  output logic               ext_wr,
  input  logic [LADDR_W-1:0] cpu_addr,
  output logic [GADDR_W-1:0] glb_addr,
  output logic               ext_acc
);
  localparam int PG_W = GADDR_W - LADDR_W;

  logic erom_en, hi_only, flash_en;
  logic hi_done, fl_done;
  logic is_emu, is_spec, in_win;

  assign is_emu  = (mode == 2'b01);
  assign is_spec = mode[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erom_en <= 1'b0;
    end else if (erom_ld) begin
      erom_en <= erom_ld_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_only <= 1'b0;
      hi_done <= 1'b0;
    end else if (reg_wr) begin
      if (is_spec || !hi_done) hi_only <= reg_wdata[1];
      hi_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flash_en <= 1'b0;
      fl_done  <= 1'b0;
    end else if (reg_wr) begin
      if (is_spec || !fl_done) flash_en <= reg_wdata[0];
      fl_done <= 1'b1;
    end
  end

  assign reg_rdata = is_emu ? ext_rdata : {5'b0, erom_en, hi_only, flash_en};
  assign ext_wr    = reg_wr && is_emu;

  assign in_win = (cpu_addr[LADDR_W-1:LADDR_W-2] == 2'b01);

  logic [PG_W-1:0] page;
  assign page     = (in_win && hi_only) ? EXT_PG : FLASH_PG;
  assign glb_addr = {page, cpu_addr};
  assign ext_acc  = in_win && (hi_only || !flash_en);
endmodule

module flashmap_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        erom_ld,
  input logic        reg_wr,
  input logic [15:0] cpu_addr,
  input logic [22:0] glb_addr,
  input logic        ext_acc,
  input logic [7:0]  reg_rdata,
  input logic        ext_wr,
  input logic        hi_only,
  input logic        flash_en,
  input logic        hi_done,
  input logic        erom_en
);
  logic win;
  assign win = (cpu_addr >= 16'h4000) && (cpu_addr <= 16'h7FFF);

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |-> (reg_rdata[7:3] == 5'b0));

  assert_erom_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !erom_ld |=> $stable(erom_en));

  assert_write_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hi_done && !mode[1]) |=> ($stable(hi_only) && $stable(flash_en)));

  assert_onchip_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !hi_only && flash_en) |-> (!ext_acc && glb_addr[22:16] == 7'h7F));

  assert_ext_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win && hi_only) |-> (ext_acc && glb_addr[22:16] == 7'h14));

  assert_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> (!ext_acc && glb_addr == {7'h7F, cpu_addr}));

  assert_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |-> (reg_wr && mode == 2'b01));
endmodule

bind flashmap_ctl flashmap_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .erom_ld(erom_ld), .reg_wr(reg_wr),
  .cpu_addr(cpu_addr), .glb_addr(glb_addr), .ext_acc(ext_acc),
  .reg_rdata(reg_rdata), .ext_wr(ext_wr), .hi_only(hi_only),
  .flash_en(flash_en), .hi_done(hi_done), .erom_en(erom_en)
);

// File: tb/flashmap_ctl_tb.sv
module flashmap_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        erom_ld = 1'b0, erom_ld_val = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h00, ext_rdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        ext_wr;
  logic [15:0] cpu_addr = 16'h0000;
  logic [22:0] glb_addr;
  logic        ext_acc;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  flashmap_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .erom_ld(erom_ld),
    .erom_ld_val(erom_ld_val), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ext_rdata(ext_rdata), .reg_rdata(reg_rdata), .ext_wr(ext_wr),
    .cpu_addr(cpu_addr), .glb_addr(glb_addr), .ext_acc(ext_acc)
  );

  // {hi_only, flash_en, addr[15:0], glb[22:0], ext}
  localparam int NV = 10;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'h4000, 23'h7F4000, 1'b0},
    {1'b0, 1'b1, 16'h7FFF, 23'h7F7FFF, 1'b0},
    {1'b1, 1'b1, 16'h4000, 23'h144000, 1'b1},
    {1'b1, 1'b1, 16'h5A5A, 23'h145A5A, 1'b1},
    {1'b0, 1'b0, 16'h6000, 23'h7F6000, 1'b1},
    {1'b1, 1'b0, 16'h7FFF, 23'h147FFF, 1'b1},
    {1'b0, 1'b1, 16'h3FFF, 23'h7F3FFF, 1'b0},
    {1'b1, 1'b0, 16'h8000, 23'h7F8000, 1'b0},
    {1'b0, 1'b0, 16'h0000, 23'h7F0000, 1'b0},
    {1'b1, 1'b1, 16'hFFFF, 23'h7FFFFF, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(reg_rdata == 8'h00, "R1 reset read", reg_rdata, 8'h00);
    cpu_addr = 16'h4100; #1;
    chk(glb_addr == 23'h7F4100 && ext_acc == 1'b1, "R1 reset map (flash off)",
        {glb_addr, ext_acc}, {23'h7F4100, 1'b1});
    @(negedge clk); rst_n = 1'b1;

    mode = 2'b10;
    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      string tag;
      v = VEC[i];
      wr({6'b0, v[41], v[40]});
      cpu_addr = v[39:24]; #1;
      if (v[39:38] != 2'b01) tag = "R9 outside";
      else if (v[41]) tag = "R7 high-half";
      else if (!v[40]) tag = "R8 flash off";
      else tag = "R6 on-chip";
      chk(glb_addr == v[23:1] && ext_acc == v[0], tag, {glb_addr, ext_acc}, v[23:0]);
      chk(reg_rdata == {6'b0, v[41], v[40]}, "R5 special rewrite / R2 layout",
          reg_rdata, {6'b0, v[41], v[40]});
    end

    // R3: software write of bit 2 ignored, load path works
    wr(8'hFF);
    chk(reg_rdata == 8'h03, "R3 sw write bit2 ignored / R2 reserved", reg_rdata, 8'h03);
    @(negedge clk); erom_ld = 1'b1; erom_ld_val = 1'b1;
    @(negedge clk); erom_ld = 1'b0; #1;
    chk(reg_rdata == 8'h07, "R3 load path", reg_rdata, 8'h07);
    wr(8'h00);
    chk(reg_rdata == 8'h04, "R3 bit2 kept on write 0", reg_rdata, 8'h04);

    // R4: write once in normal mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; mode = 2'b00;
    cpu_addr = 16'h4800;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h01; #1;
    chk(ext_acc == 1'b1, "R11 old map before edge", ext_acc, 1'b1);
    @(negedge clk); reg_wr = 1'b0; #1;
    chk(ext_acc == 1'b0 && glb_addr == 23'h7F4800, "R11 new map after edge",
        {glb_addr, ext_acc}, {23'h7F4800, 1'b0});
    wr(8'h02);
    chk(reg_rdata == 8'h01, "R4 second write ignored (normal)", reg_rdata, 8'h01);
    chk(glb_addr == 23'h7F4800 && !ext_acc, "R4 map unchanged", {glb_addr, ext_acc}, {23'h7F4800, 1'b0});
    mode = 2'b11;
    wr(8'h02);
    chk(reg_rdata == 8'h02, "R5 special after lock", reg_rdata, 8'h02);
    chk(glb_addr == 23'h144800 && ext_acc, "R7 after special write", {glb_addr, ext_acc}, {23'h144800, 1'b1});

    // R4 + R10: emulation mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; mode = 2'b01; ext_rdata = 8'hA5; #1;
    chk(reg_rdata == 8'hA5, "R10 emu read from ext bus", reg_rdata, 8'hA5);
    chk(ext_wr == 1'b0, "R10 no fwd when idle", ext_wr, 1'b0);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h03; #1;
    chk(ext_wr == 1'b1, "R10 write forwarded", ext_wr, 1'b1);
    @(negedge clk); reg_wr = 1'b0;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h01;
    @(negedge clk); reg_wr = 1'b0; mode = 2'b00; #1;
    chk(reg_rdata == 8'h03, "R4 emu second write ignored", reg_rdata, 8'h03);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h00; #1;
    chk(ext_wr == 1'b0, "R10 no fwd in normal", ext_wr, 1'b0);
    @(negedge clk); reg_wr = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule